// File: doc/BRIEF.md
# Hypervisor Bandwidth-Cap Control Register

This block holds a 64-bit control register that lets a hypervisor place a ceiling on the memory bandwidth granted to a guest. It also decides the outcome of every read or write request aimed at that register. Each request carries the current exception level (0 to 3), three nested-virtualization control bits, two trap controls owned by the most privileged level, and the capability inputs. The outcome is one of four:

- a direct access to the register,
- a redirect to a memory offset,
- a trap to EL2 or EL3 with a fixed syndrome class,
- an UNDEFINED response.

The access path is a small response state machine. Its states are ST_IDLE, ST_DIRECT, ST_REDIR, ST_TRAP and ST_UNDEF. A request in any state moves the machine to the state of its outcome, so back-to-back requests are accepted. A cycle with no request returns the machine to ST_IDLE. Each outcome state lasts exactly one cycle and drives the matching response flag.

The cap field changes meaning at run time. It is a 16-bit pure fraction when hardware scaling is off. It is a 16.16 fixed-point multiplier when hardware scaling is both supported and enabled. The block also produces an effective limit in 16.16 format. That limit is the smaller of the normalized cap and the lower level's maximum setting, and it applies only while capping is enabled and the host-mode pair is not both set.

Top module: `bwcap_vreg`

## Requirements
- R1: After reset all four response flags are low, `rd_data`, `redir_off`, `trap_el` and `trap_ec` are zero, and a direct read returns all zeros.
- R2: Register layout on read:
  - bit 63 is the hardware-scale enable; it stores a written 1 only while `hw_scale_cap` is 1 and reads as 0 while `hw_scale_cap` is 0;
  - bit 62 is the cap enable;
  - bits 61:32 always read 0.
- R3: When bit 63 reads 1, cap bits 31:16 (integer part) are readable. Otherwise bits 31:16 read 0, and bits 15:0 hold the fraction.
- R4: With fractional width `frac_width` (values above 16 are treated as 16), cap bits (15−width) down to 0 read 0.
- R5: A request is UNDEFINED when `feat_impl` or `hcr_cap` is 0, or when `cur_el` is 0.
- R6: At EL1 with `nv_bits[2]` and `nv_bits[0]` both 1, the request is redirected with `redir_off` = 0x910.
- R7: At EL1 with `nv_bits[0]`=1 but not R6, the trap target is chosen in this order:
  - EL3 when `el3_present` and `el3_trap_lower` are both 1;
  - otherwise EL3 when `el3_present` is 1 and `el3_ntrap_lower` is 0;
  - otherwise EL2.
  
  `trap_el` gives the target as 2 or 3, and `trap_ec` is 0x18. At EL1 with `nv_bits[0]`=0 the request is UNDEFINED.
- R8: At EL2, if `el3_present` is 1 and either EL3 trap condition from R7 holds, the request is UNDEFINED when `el3_undef_prio` is 1 and traps to EL3 otherwise. If no trap condition holds, the access is direct. At EL3 every access is direct.
- R9: A redirected, trapped or UNDEFINED write leaves the register unchanged. `rd_data` is zero except on a direct read, where it returns the value held before that cycle's edge.
- R10: The response flags are at most one-hot. A flag is high exactly in the cycle after its request, and a cycle with no request produces no flag.
- R11: `eff_limit` equals min(normalized cap, `lower_max`) when bit 62 is 1 and not both `host_e2h` and `host_tge` are 1; otherwise it equals `lower_max`. The normalized cap is the readable bits 31:0 in 16.16 format. A written value shows in `eff_limit` from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data |
| cur_el | input | 2 | Current exception level 0..3 |
| nv_bits | input | 3 | Nested-virtualization bits: [2]=NV2, [1]=NV1, [0]=NV |
| feat_impl | input | 1 | Bandwidth-control feature present |
| hcr_cap | input | 1 | Hypervisor-control capability present |
| el3_present | input | 1 | EL3 implemented |
| el3_trap_lower | input | 1 | EL3 trap control, traps when 1 |
| el3_ntrap_lower | input | 1 | EL3 trap control, traps when 0 |
| el3_undef_prio | input | 1 | At EL2, turn EL3 traps into UNDEFINED |
| hw_scale_cap | input | 1 | Hardware scaling supported |
| frac_width | input | 5 | Implemented fractional width, 0..16 |
| host_e2h | input | 1 | Host-mode bit E2H |
| host_tge | input | 1 | Host-mode bit TGE |
| lower_max | input | 32 | Lower level maximum, 16.16 |
| resp_direct | output | 1 | Direct access response |
| resp_redirect | output | 1 | Redirect-to-memory response |
| resp_trap | output | 1 | Trap response |
| resp_undef | output | 1 | UNDEFINED response |
| rd_data | output | 64 | Read data on a direct read |
| redir_off | output | 12 | Redirect memory offset |
| trap_el | output | 2 | Trap target level |
| trap_ec | output | 6 | Trap syndrome class |
| eff_limit | output | 32 | Effective bandwidth limit, 16.16 |

## Verification
Several corner cases are targeted directly:

- **Redirect pattern.** An EL1 request with NV=1, NV1=0 and NV2=1 must redirect. A design that matched only NV with NV2 clear would trap it instead.
- **EL2 trap rules.** The two EL3 trap conditions are swept with the undefined-priority input both set and clear. A wrong check order would give a trap where UNDEFINED is expected.
- **Scaled integer bits.** A write of all ones with scaling supported is read back, then scaling support is withdrawn. A design that failed to hide the integer bits would leak them into the read data and into `eff_limit`.
- **Fraction width.** Several widths are tested, including 0, 16 and over-range values. A design that cut the fraction off at the wrong bit would read back or limit with the wrong value.

Randomized sequences write through redirected and trapped paths and read the register back afterwards. Any write that leaked into the register shows up there.

// File: rtl/bwcap_pkg.sv
package bwcap_pkg;
    localparam int DATA_W = 64;
    localparam int CAP_W  = 32;
    localparam int FRAC_W = 16;
    localparam int FW_W   = 5;
    localparam int OFF_W  = 12;
    localparam int EC_W   = 6;

    localparam logic [OFF_W-1:0] REDIR_OFFSET = 12'h910;
    localparam logic [EC_W-1:0]  TRAP_CLASS   = 6'h18;

    typedef enum logic [1:0] {
        ACC_DIRECT = 2'd0,
        ACC_REDIR  = 2'd1,
        ACC_TRAP   = 2'd2,
        ACC_UNDEF  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e  kind;
        logic [1:0] target;
    } acc_dec_t;
endpackage

// File: rtl/bwcap_access_dec.sv
module bwcap_access_dec
    import bwcap_pkg::*;
(
    input  logic [1:0] cur_el,
    input  logic [2:0] nv_bits,
    input  logic       feat_impl,
    input  logic       hcr_cap,
    input  logic       el3_present,
    input  logic       el3_trap_lower,
    input  logic       el3_ntrap_lower,
    input  logic       el3_undef_prio,
    output acc_dec_t   dec
);
    logic trap_a;
    logic trap_b;
    logic any_el3_trap;

    assign trap_a       = el3_present && el3_trap_lower;
    assign trap_b       = el3_present && !el3_ntrap_lower;
    assign any_el3_trap = trap_a || trap_b;

    always_comb begin
        dec.kind   = ACC_UNDEF;
        dec.target = 2'd0;
        if (feat_impl && hcr_cap) begin
            unique case (cur_el)
                2'd0: dec.kind = ACC_UNDEF;
                2'd1: begin
                    if (nv_bits[2] && nv_bits[0]) begin
                        dec.kind = ACC_REDIR;
                    end else if (nv_bits[0]) begin
                        dec.kind   = ACC_TRAP;
                        dec.target = any_el3_trap ? 2'd3 : 2'd2;
                    end else begin
                        dec.kind = ACC_UNDEF;
                    end
                end
                2'd2: begin
                    if (any_el3_trap && el3_undef_prio) begin
                        dec.kind = ACC_UNDEF;
                    end else if (any_el3_trap) begin
                        dec.kind   = ACC_TRAP;
                        dec.target = 2'd3;
                    end else begin
                        dec.kind = ACC_DIRECT;
                    end
                end
                2'd3: dec.kind = ACC_DIRECT;
                default: dec.kind = ACC_UNDEF;
            endcase
        end
    end
endmodule

// File: rtl/bwcap_cap_reg.sv
module bwcap_cap_reg
    import bwcap_pkg::*;
#(
    parameter int P_DATA_W = DATA_W,
    parameter int P_CAP_W  = CAP_W,
    parameter int P_FRAC_W = FRAC_W,
    parameter int P_FW_W   = FW_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [P_DATA_W-1:0] wdata,
    input  logic                hw_scale_cap,
    input  logic [P_FW_W-1:0]   frac_width,
    output logic [P_DATA_W-1:0] view,
    output logic                cap_en,
    output logic [P_CAP_W-1:0]  cap_norm
);
    localparam int INT_W  = P_CAP_W - P_FRAC_W;
    localparam int RSVD_W = P_DATA_W - 2 - P_CAP_W;

    logic               hs_q;
    logic               en_q;
    logic [P_CAP_W-1:0] cap_q;
    logic [P_FW_W-1:0]  fw_c;
    logic [P_FRAC_W-1:0] fmask;
    logic               hs_eff;
    logic [P_CAP_W-1:0] cap_v;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q  <= 1'b0;
            en_q  <= 1'b0;
            cap_q <= '0;
        end else if (wr_en) begin
            hs_q  <= wdata[P_DATA_W-1] && hw_scale_cap;
            en_q  <= wdata[P_DATA_W-2];
            cap_q <= wdata[P_CAP_W-1:0];
        end
    end

    assign fw_c = (frac_width > P_FW_W'(P_FRAC_W)) ? P_FW_W'(P_FRAC_W) : frac_width;

    always_comb begin
        for (int i = 0; i < P_FRAC_W; i++) begin
            fmask[i] = (i >= (P_FRAC_W - int'(fw_c)));
        end
    end

    assign hs_eff = hs_q && hw_scale_cap;
    assign cap_v  = {(hs_eff ? cap_q[P_CAP_W-1:P_FRAC_W] : {INT_W{1'b0}}),
                     cap_q[P_FRAC_W-1:0] & fmask};

    assign view     = {hs_eff, en_q, {RSVD_W{1'b0}}, cap_v};
    assign cap_en   = en_q;
    assign cap_norm = cap_v;

    // R9
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cap_q) && $stable(en_q));
endmodule

// File: rtl/bwcap_vreg.sv
module bwcap_vreg
    import bwcap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [63:0] req_wdata,
    input  logic [1:0]  cur_el,
    input  logic [2:0]  nv_bits,
    input  logic        feat_impl,
    input  logic        hcr_cap,
    input  logic        el3_present,
    input  logic        el3_trap_lower,
    input  logic        el3_ntrap_lower,
    input  logic        el3_undef_prio,
    input  logic        hw_scale_cap,
    input  logic [4:0]  frac_width,
    input  logic        host_e2h,
    input  logic        host_tge,
    input  logic [31:0] lower_max,
    output logic        resp_direct,
    output logic        resp_redirect,
    output logic        resp_trap,
    output logic        resp_undef,
    output logic [63:0] rd_data,
    output logic [11:0] redir_off,
    output logic [1:0]  trap_el,
    output logic [5:0]  trap_ec,
    output logic [31:0] eff_limit
);
    typedef enum logic [2:0] {
        ST_IDLE, ST_DIRECT, ST_REDIR, ST_TRAP, ST_UNDEF
    } st_e;

    st_e               state_q, state_d;
    acc_dec_t          dec;
    logic [DATA_W-1:0] view;
    logic              cap_en;
    logic [CAP_W-1:0]  cap_norm;
    logic              wr_en;
    logic [DATA_W-1:0] rdata_q;
    logic [1:0]        tgt_q;
    logic              apply_cap;

    bwcap_access_dec u_dec (
        .cur_el          (cur_el),
        .nv_bits         (nv_bits),
        .feat_impl       (feat_impl),
        .hcr_cap         (hcr_cap),
        .el3_present     (el3_present),
        .el3_trap_lower  (el3_trap_lower),
        .el3_ntrap_lower (el3_ntrap_lower),
        .el3_undef_prio  (el3_undef_prio),
        .dec             (dec)
    );

    assign wr_en = req_valid && req_write && (dec.kind == ACC_DIRECT);

    bwcap_cap_reg u_reg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wdata        (req_wdata),
        .hw_scale_cap (hw_scale_cap),
        .frac_width   (frac_width),
        .view         (view),
        .cap_en       (cap_en),
        .cap_norm     (cap_norm)
    );

    // Next-state: every request goes to its outcome state.
    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            unique case (dec.kind)
                ACC_DIRECT: state_d = ST_DIRECT;
                ACC_REDIR:  state_d = ST_REDIR;
                ACC_TRAP:   state_d = ST_TRAP;
                ACC_UNDEF:  state_d = ST_UNDEF;
                default:    state_d = ST_UNDEF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
            tgt_q   <= 2'd0;
        end else begin
            state_q <= state_d;
            rdata_q <= (state_d == ST_DIRECT && !req_write) ? view : '0;
            tgt_q   <= (state_d == ST_TRAP) ? dec.target : 2'd0;
        end
    end

    always_comb begin
        resp_direct   = 1'b0;
        resp_redirect = 1'b0;
        resp_trap     = 1'b0;
        resp_undef    = 1'b0;
        rd_data       = '0;
        redir_off     = '0;
        trap_el       = 2'd0;
        trap_ec       = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DIRECT: begin
                resp_direct = 1'b1;
                rd_data     = rdata_q;
            end
            ST_REDIR: begin
                resp_redirect = 1'b1;
                redir_off     = REDIR_OFFSET;
            end
            ST_TRAP: begin
                resp_trap = 1'b1;
                trap_el   = tgt_q;
                trap_ec   = TRAP_CLASS;
            end
            ST_UNDEF: resp_undef = 1'b1;
            default: ;
        endcase
    end

    assign apply_cap = cap_en && !(host_e2h && host_tge);
    assign eff_limit = (apply_cap && (cap_norm < lower_max)) ? cap_norm : lower_max;

    // R10
    resp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({resp_direct, resp_redirect, resp_trap, resp_undef}));
    // R5
    el0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cur_el == 2'd0) |=> resp_undef);
    // R6
    redir_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_redirect |-> redir_off == 12'h910);
    // R7
    trap_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_trap |-> (trap_ec == 6'h18) && (trap_el[1] == 1'b1));
    // R9
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_direct |-> rd_data == 64'd0);
    // R11
    eff_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eff_limit <= lower_max);
endmodule

// File: tb/bwcap_vreg_tb.sv
module bwcap_vreg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0;
    logic [63:0] req_wdata = '0;
    logic [1:0]  cur_el = 0;
    logic [2:0]  nv_bits = 0;
    logic        feat_impl = 1, hcr_cap = 1, el3_present = 0;
    logic        el3_trap_lower = 0, el3_ntrap_lower = 1, el3_undef_prio = 0;
    logic        hw_scale_cap = 1;
    logic [4:0]  frac_width = 5'd16;
    logic        host_e2h = 0, host_tge = 0;
    logic [31:0] lower_max = 32'hFFFF_FFFF;
    logic        resp_direct, resp_redirect, resp_trap, resp_undef;
    logic [63:0] rd_data;
    logic [11:0] redir_off;
    logic [1:0]  trap_el;
    logic [5:0]  trap_ec;
    logic [31:0] eff_limit;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    logic        m_hs = 0, m_en = 0;
    logic [31:0] m_cap = '0;

    always #4 clk = ~clk;

    bwcap_vreg dut_i (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] view_f();
        logic hs;
        logic [31:0] c;
        int f;
        hs = m_hs && hw_scale_cap;
        c = m_cap;
        if (!hs) c[31:16] = 16'h0;
        f = (frac_width > 5'd16) ? 16 : int'(frac_width);
        for (int i = 0; i < 16; i++) if (i < 16 - f) c[i] = 1'b0;
        return {hs, m_en, 30'h0, c};
    endfunction

    // returns kind: 0 direct,1 redir,2 trap,3 undef; tgt by ref
    function automatic int dec_f(output int tgt);
        logic t3;
        tgt = 0;
        t3 = (el3_present && el3_trap_lower) || (el3_present && !el3_ntrap_lower);
        if (!feat_impl || !hcr_cap || cur_el == 0) return 3;
        if (cur_el == 1) begin
            if (nv_bits[2] && nv_bits[0]) return 1;
            if (nv_bits[0]) begin tgt = t3 ? 3 : 2; return 2; end
            return 3;
        end
        if (cur_el == 2) begin
            if (t3 && el3_undef_prio) return 3;
            if (t3) begin tgt = 3; return 2; end
            return 0;
        end
        return 0;
    endfunction

    function automatic logic [31:0] eff_f();
        logic [31:0] c;
        c = view_f()[31:0];
        if (m_en && !(host_e2h && host_tge) && c < lower_max) return c;
        return lower_max;
    endfunction

    function automatic string tag_f();
        if (!feat_impl || !hcr_cap || cur_el == 0) return "R5";
        if (cur_el == 1) return (nv_bits[2] && nv_bits[0]) ? "R6" : "R7";
        return "R8";
    endfunction

    // called at a negedge with inputs set; checks one cycle
    task automatic step();
        int k, tgt;
        logic [63:0] exp_rd;
        string tg;
        k = dec_f(tgt);
        tg = tag_f();
        exp_rd = (req_valid && k == 0 && !req_write) ? view_f() : 64'h0;
        @(posedge clk);
        if (req_valid && k == 0 && req_write) begin
            m_hs = req_wdata[63] && hw_scale_cap;
            m_en = req_wdata[62];
            m_cap = req_wdata[31:0];
        end
        @(negedge clk);
        if (!req_valid) begin
            chk("R10 idle", {60'h0, resp_direct, resp_redirect, resp_trap, resp_undef}, 64'h0);
        end else begin
            chk({tg, " kind R10"}, {60'h0, resp_direct, resp_redirect, resp_trap, resp_undef},
                {60'h0, k == 0, k == 1, k == 2, k == 3});
            chk({tg, " target"}, {50'h0, trap_el, trap_ec, redir_off},
                {50'h0, (k == 2) ? 2'(tgt) : 2'd0, (k == 2) ? 6'h18 : 6'h0,
                 (k == 1) ? 12'h910 : 12'h0});
            chk("R2 R3 R4 R9 rdata", rd_data, exp_rd);
        end
        chk("R11 eff", {32'h0, eff_limit}, {32'h0, eff_f()});
    endtask

    task automatic acc(input logic w, input logic [63:0] d, input logic [1:0] el, input logic [2:0] nv);
        req_valid = 1; req_write = w; req_wdata = d; cur_el = el; nv_bits = nv;
        step();
        req_valid = 0;
    endtask

    initial begin
        #(8 * 190000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 flags", {60'h0, resp_direct, resp_redirect, resp_trap, resp_undef}, 64'h0);
        chk("R1 rd", rd_data, 64'h0);
        rst_n = 1;
        @(negedge clk);
        acc(0, 0, 2'd3, 3'b000);                  // R1 readback zero
        // R2 R3 full write with scaling supported
        acc(1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 3'b000);
        acc(0, 0, 2'd3, 3'b000);
        hw_scale_cap = 0;                          // R3 integer bits hidden
        acc(0, 0, 2'd3, 3'b000);
        for (int fw = 0; fw <= 20; fw += 4) begin  // R4 widths incl over-range
            frac_width = 5'(fw);
            acc(0, 0, 2'd3, 3'b000);
        end
        frac_width = 5'd16;
        // R6 redirect write must not land (R9)
        acc(1, 64'h4000_0000_0000_1234, 2'd1, 3'b101);
        acc(0, 0, 2'd3, 3'b000);
        // R7 trap ordering at EL1
        el3_present = 1; el3_trap_lower = 1; acc(1, 64'h0, 2'd1, 3'b001);
        el3_trap_lower = 0; el3_ntrap_lower = 0; acc(0, 0, 2'd1, 3'b011);
        el3_ntrap_lower = 1; acc(0, 0, 2'd1, 3'b001);
        acc(0, 0, 2'd1, 3'b100);                  // R7 undefined, NV clear
        // R8 EL2 with undefined priority
        el3_trap_lower = 1; el3_undef_prio = 1; acc(1, 64'h0, 2'd2, 3'b000);
        el3_undef_prio = 0; acc(0, 0, 2'd2, 3'b000);
        el3_trap_lower = 0; acc(0, 0, 2'd2, 3'b000);
        // R5 feature absent
        hcr_cap = 0; acc(0, 0, 2'd3, 3'b000); hcr_cap = 1;
        // R11 host mode bypass
        lower_max = 32'h0000_8000; host_e2h = 1; host_tge = 1;
        req_valid = 0; step();
        host_tge = 0; step();
        // random mix
        for (int n = 0; n < 4000; n++) begin
            req_valid       = ($urandom % 5) != 0;
            req_write       = $urandom % 2;
            req_wdata       = {$urandom, $urandom};
            cur_el          = 2'($urandom);
            nv_bits         = 3'($urandom);
            feat_impl       = ($urandom % 10) != 0;
            hcr_cap         = ($urandom % 10) != 0;
            el3_present     = $urandom % 2;
            el3_trap_lower  = ($urandom % 4) == 0;
            el3_ntrap_lower = ($urandom % 4) != 0;
            el3_undef_prio  = $urandom % 2;
            if ($urandom % 16 == 0) hw_scale_cap = $urandom % 2;
            if ($urandom % 16 == 0) frac_width = 5'($urandom % 18);
            host_e2h        = $urandom % 2;
            host_tge        = $urandom % 2;
            lower_max       = $urandom;
            step();
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule